// File: doc/BRIEF.md
# Correctable Error Threshold Counter

This block sits beside the single-bit correction stage on an emulated-EEPROM read path. Each time that stage reports a corrected error while profiling is switched on, a 16-bit tally advances. When the tally reaches a programmed nonzero limit, it returns to zero and the block raises a one-cycle interrupt request. A limit of zero turns triggering off, and the tally then stops at its maximum value instead of wrapping.

Software reaches two 32-bit registers through a small word-addressed port. One register holds the limit and the other holds the tally. Reads are open in every mode. Writes take effect only when the privilege input is high. Writing any value to the tally register clears it. The error-injection controls that force zeros or ones in the correction stage have no path into this block, so they cannot alter the tally.

Top module: `corr_err_thresh`

## Requirements
- R1: After reset the limit and the tally both read 0 and `irq` is low.
- R2: Word address 0 reads the limit and word address 1 reads the tally, each in bits 15:0. Bits 31:16 always read 0, any other address reads 0, and a read needs no privilege.
- R3: A privileged write to address 0 stores `reg_wdata[15:0]` as the limit. Bits 31:16 of the written word are dropped.
- R4: A write with `reg_priv` low changes neither the limit nor the tally.
- R5: A privileged write to address 1 sets the tally to 0, whatever value is written.
- R6: The tally rises by one for each cycle in which `err_strobe` and `profile_en` are both high. While `profile_en` is low, a strobe leaves the tally unchanged.
- R7: When an increment would bring the tally to or past a nonzero limit, the tally becomes 0 instead. `irq` is then high for exactly the one cycle after that clock edge, so a limit of 1 raises `irq` on every counted event.
- R8: With the limit at 0, `irq` never rises and the tally holds at 0xFFFF rather than wrapping.
- R9: When a privileged tally write and a counted event fall in the same cycle, the tally becomes 0 and `irq` stays low.
- R10: A new limit applies from the next cycle onward. An event in the same cycle as a limit write is judged against the old limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_priv | input | 1 | High when the current access is privileged |
| reg_addr | input | ADDR_W | Word address (0 = limit, 1 = tally) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| err_strobe | input | 1 | One pulse per corrected single-bit error |
| profile_en | input | 1 | Profiling enable; events are counted only while high |
| irq | output | 1 | One-cycle interrupt request |

## Verification
If the tally register goes wrong, the fault appears on the very next read of address 1. If the comparison goes wrong, the fault appears on `irq` one cycle after the event that should have fired, or should not have fired. The limit register has no effect of its own on the outputs, so a corrupted limit shows up only as an `irq` that comes early, comes late or never comes. For that reason the limit is also read back directly after every write to it. The saturation case needs a full 65,535 counted events before it can show anything, so the bench runs it end to end.

// File: rtl/ceth_pkg.sv
package ceth_pkg;

    parameter int DATA_W = 32;
    parameter int CNT_W  = 16;
    parameter int THR_WORD = 0;
    parameter int CNT_WORD = 1;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic thr_we;
        logic cnt_clr;
        cnt_t field;
    } wr_req_t;

    typedef struct packed {
        logic fire;
        logic hold;
    } cnt_evt_t;

    function automatic word_t widen(input cnt_t v);
        return {{(DATA_W-CNT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/ceth_wr_decode.sv
module ceth_wr_decode
    import ceth_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              reg_wr,
    input  logic              reg_priv,
    input  logic [ADDR_W-1:0] reg_addr,
    input  word_t             reg_wdata,
    output wr_req_t           req
);
    logic ok;

    always_comb begin
        ok          = reg_wr && reg_priv;
        req.thr_we  = ok && (reg_addr == ADDR_W'(THR_WORD));
        req.cnt_clr = ok && (reg_addr == ADDR_W'(CNT_WORD));
        req.field   = reg_wdata[CNT_W-1:0];
    end
endmodule

// File: rtl/ceth_thr_reg.sv
module ceth_thr_reg
    import ceth_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    output cnt_t    thr_q
);
    always_ff @(posedge clk) begin
        if (rst)
            thr_q <= '0;
        else if (req.thr_we)
            thr_q <= req.field;
    end
endmodule

// File: rtl/ceth_counter.sv
module ceth_counter
    import ceth_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    err_strobe,
    input  logic    profile_en,
    input  logic    cnt_clr,
    input  cnt_t    thr_q,
    output cnt_t    cnt_q,
    output logic    irq
);
    logic           counted;
    logic [CNT_W:0] bumped;
    cnt_evt_t       evt;
    cnt_t           cnt_d;

    always_comb begin
        counted  = err_strobe && profile_en;
        bumped   = {1'b0, cnt_q} + 1'b1;
        evt.fire = counted && (thr_q != '0) && (bumped >= {1'b0, thr_q});
        evt.hold = (thr_q == '0) && (cnt_q == '1);
        if (cnt_clr)
            cnt_d = '0;
        else if (!counted || evt.hold)
            cnt_d = cnt_q;
        else if (evt.fire)
            cnt_d = '0;
        else
            cnt_d = bumped[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq   <= evt.fire && !cnt_clr;
        end
    end
endmodule

// File: rtl/ceth_rd_mux.sv
module ceth_rd_mux
    import ceth_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  cnt_t              thr_q,
    input  cnt_t              cnt_q,
    output word_t             reg_rdata
);
    always_comb begin
        if (reg_addr == ADDR_W'(THR_WORD))
            reg_rdata = widen(thr_q);
        else if (reg_addr == ADDR_W'(CNT_WORD))
            reg_rdata = widen(cnt_q);
        else
            reg_rdata = '0;
    end
endmodule

// File: rtl/corr_err_thresh.sv
module corr_err_thresh
    import ceth_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_priv,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              err_strobe,
    input  logic              profile_en,
    output logic              irq
);
    wr_req_t req;
    cnt_t    thr_q;
    cnt_t    cnt_q;

    ceth_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .reg_wr    (reg_wr),
        .reg_priv  (reg_priv),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .req       (req)
    );

    ceth_thr_reg u_thr (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .thr_q (thr_q)
    );

    ceth_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .err_strobe (err_strobe),
        .profile_en (profile_en),
        .cnt_clr    (req.cnt_clr),
        .thr_q      (thr_q),
        .cnt_q      (cnt_q),
        .irq        (irq)
    );

    ceth_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
        .reg_addr  (reg_addr),
        .thr_q     (thr_q),
        .cnt_q     (cnt_q),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: rtl/corr_err_thresh_chk.sv
module corr_err_thresh_chk
    import ceth_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_priv,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              err_strobe,
    input logic              profile_en,
    input logic              irq,
    input cnt_t              thr_q,
    input cnt_t              cnt_q
);
    logic cnt_wr, thr_wr, counted;
    assign cnt_wr  = reg_wr && reg_priv && (reg_addr == ADDR_W'(CNT_WORD));
    assign thr_wr  = reg_wr && reg_priv && (reg_addr == ADDR_W'(THR_WORD));
    assign counted = err_strobe && profile_en;

    // R2
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[31:16] == 16'h0);

    // R4 / R3
    p_thr_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !thr_wr |=> $stable(thr_q));

    // R5 / R9
    p_cnt_clear_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt_q == '0) && !irq);

    // R6
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!counted && !cnt_wr) |=> $stable(cnt_q));

    // R7
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        !counted |=> !irq);

    p_irq_zero_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> cnt_q == '0);

    // R8
    p_no_irq_zero_thr_r8: assert property (@(posedge clk) disable iff (rst)
        (thr_q == '0) |=> !irq);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        ((thr_q == '0) && (cnt_q == '1) && !cnt_wr) |=> cnt_q == '1);
endmodule

bind corr_err_thresh corr_err_thresh_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_priv   (reg_priv),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .err_strobe (err_strobe),
    .profile_en (profile_en),
    .irq        (irq),
    .thr_q      (thr_q),
    .cnt_q      (cnt_q)
);

// File: tb/corr_err_thresh_bench.sv
`timescale 1ns/1ps
module corr_err_thresh_bench;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0, reg_priv = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          err_strobe = 1'b0, profile_en = 1'b0;
    logic          irq;

    always #4 clk = ~clk;

    corr_err_thresh #(.ADDR_W(AW)) u_corr_err_thresh (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_priv(reg_priv),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_strobe(err_strobe), .profile_en(profile_en), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    logic        q_irq[$];
    logic [31:0] q_rd[$];
    string       q_tag[$];

    logic [15:0] m_thr = '0, m_cnt = '0;
    int          irq_seen = 0;

    task automatic step(input logic wr, input logic [AW-1:0] a, input logic [31:0] wd,
                        input logic pv, input logic es, input logic pe, input string tag);
        logic [15:0] t_old;
        logic        e_irq;
        logic [31:0] e_rd;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd; reg_priv = pv;
        err_strobe = es; profile_en = pe;
        t_old = m_thr; e_irq = 1'b0;
        if (wr && pv && a == 1) m_cnt = '0;
        else if (es && pe) begin
            if (t_old != 0 && ({1'b0, m_cnt} + 17'd1) >= {1'b0, t_old}) begin
                m_cnt = '0; e_irq = 1'b1;
            end else if (!(t_old == 0 && m_cnt == 16'hFFFF)) m_cnt = m_cnt + 1;
        end
        if (wr && pv && a == 0) m_thr = wd[15:0];
        e_rd = (a == 0) ? {16'h0, m_thr} : (a == 1) ? {16'h0, m_cnt} : 32'h0;
        q_irq.push_back(e_irq); q_rd.push_back(e_rd); q_tag.push_back(tag);
    endtask

    always begin
        @(posedge clk); #2;
        if (irq) irq_seen++;
        if (q_tag.size() > 0) begin
            logic e_i; logic [31:0] e_r; string t;
            e_i = q_irq.pop_front(); e_r = q_rd.pop_front(); t = q_tag.pop_front();
            n_chk++;
            if (irq !== e_i || reg_rdata !== e_r) begin
                n_bad++;
                $display("FAIL %s: irq=%0b rdata=%h expected irq=%0b rdata=%h", t, irq, reg_rdata, e_i, e_r);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        step(0, 0, 0, 0, 0, 0, "R1");
        step(0, 1, 0, 0, 0, 0, "R1");
        // R2 unused addresses, unprivileged reads
        step(0, 2, 0, 0, 0, 0, "R2");
        step(0, 3, 0, 1, 0, 0, "R2");
        // R3 privileged limit write, upper bits dropped
        step(1, 0, 32'hABCD_0005, 1, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, "R3");
        // R4 unprivileged limit write ignored
        step(1, 0, 32'h0000_0009, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, "R4");
        // R6 strobes without profiling ignored, then counting
        step(0, 1, 0, 0, 1, 0, "R6");
        step(0, 1, 0, 0, 1, 0, "R6");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 1, 1, "R6");
        // R4 unprivileged tally write ignored
        step(1, 1, 0, 0, 0, 1, "R4");
        // R7 fifth event reaches limit 5
        step(0, 1, 0, 0, 1, 1, "R7");
        step(0, 1, 0, 0, 1, 1, "R7");
        step(0, 1, 0, 0, 0, 1, "R7");
        // R5 clear with nonzero data
        step(1, 1, 32'hFFFF_FFFF, 1, 0, 1, "R5");
        step(0, 1, 0, 0, 1, 1, "R5");
        // R9 write and event together
        step(1, 1, 32'h1234, 1, 1, 1, "R9");
        step(0, 1, 0, 0, 0, 1, "R9");
        // R10 limit written with event: old limit 5 applies
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 1, 1, "R10");
        step(1, 0, 32'h2, 1, 1, 1, "R10");
        step(0, 1, 0, 0, 1, 1, "R10");
        step(0, 1, 0, 0, 0, 0, "R10");
        // R7 limit 1 fires every event
        step(1, 0, 32'h1, 1, 0, 0, "R7");
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 1, 1, "R7");
        step(0, 1, 0, 0, 0, 1, "R7");
        // R8 limit zero: saturate, never fire
        step(1, 0, 32'h0, 1, 0, 0, "R8");
        irq_seen = 0;
        for (int i = 0; i < 65540; i++) step(0, 1, 0, 0, 1, 1, "R8");
        step(0, 1, 0, 0, 0, 0, "R8");
        repeat (3) @(posedge clk);
        #3;
        n_chk++;
        if (irq_seen != 0) begin
            n_bad++;
            $display("FAIL R8: irq pulses=%0d expected=0", irq_seen);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule